// File: doc/BRIEF.md
# Erase-Before-Write Flash Array Emulator

This block models a small flash array in ordinary registers, so that software and controller logic can be tried against flash write rules without a real device. Storage is split into blocks, each block into pages, and each page into data words. A page is read or programmed one word per beat. An erase always covers a whole block. A program can only pull bits from one toward zero, because the stored word is ANDed with the incoming word. The only way back to all ones is a block erase.

A request is a single-cycle command with an operation code, a block number and a page number. The block answers with `busy` for the whole operation and a one-cycle `done` pulse at the end. Program and erase each add a parameterised settle time. The erase time is meant to be much longer than the program time. Every page carries a flag that records whether it has been programmed since its block was last erased. A second program to a flagged page is reported on `prog_err` together with `done`, and its AND is still applied. `BLOCKS`, `PAGES_PER_BLOCK` and `WORDS_PER_PAGE` must be powers of two, at least 2 each.

The controller has six states:
- `S_IDLE` moves to `S_READ`, `S_PROG` or `S_ERASE` when a command is accepted.
- `S_READ` moves to `S_DONE` after the last word.
- `S_PROG` moves to `S_WAIT` after the last beat.
- `S_ERASE` moves to `S_WAIT` after one cycle.
- `S_WAIT` moves to `S_DONE` when its timer runs out.
- `S_DONE` returns to `S_IDLE`.

Top module: `flash_emu`

## Requirements
- R1: After reset every stored word reads as all ones, `busy` is low and `done` is low.
- R2: A program beat stores the old word AND `wr_data`. A one bit in `wr_data` leaves the stored bit unchanged, so no bit ever goes from 0 to 1 except by erase.
- R3: Repeated programs of one word give the running AND. Writing 0xFE, 0xFA, 0xF2 and then 0xF0 over an erased word reads back as exactly those values in turn.
- R4: An erase sets every word of the addressed block to all ones and leaves all other blocks unchanged.
- R5: `prog_err` is high only in the `done` cycle of a program whose page was already programmed since its last block erase. An erase clears the flags of all pages in its block.
- R6: A read returns `WORDS_PER_PAGE` words, word 0 first, one per cycle with `rd_valid` high. The first word appears in the cycle after acceptance. `done` follows in the cycle after the last word.
- R7: Counting the cycle after acceptance as cycle 1, `done` is high for exactly one cycle, in cycle WORDS_PER_PAGE+1 for a read, WORDS_PER_PAGE+PROG_CYCLES+1 for a gap-free program, and ERASE_CYCLES+2 for an erase.
- R8: A command presented while `busy` is high is ignored. It changes no data, no flag and no timing.
- R9: `cmd_op` encoding is 2'b01 read, 2'b10 program, 2'b11 erase. Code 2'b00 is a no-op, and `busy` stays low.
- R10: During a program, a word index advances only on cycles with `wr_valid` high. Gaps delay completion by one cycle each and do not alter the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Operation code (see R9) |
| cmd_block | input | $clog2(BLOCKS) | Block number |
| cmd_page | input | $clog2(PAGES_PER_BLOCK) | Page within the block |
| wr_valid | input | 1 | Program beat valid |
| wr_data | input | DATA_W | Program beat data |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DATA_W | Read word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prog_err | output | 1 | Repeated program of a page, valid with done |

## Verification
The AND rule is driven with three kinds of program data on already-programmed words:
- Words of all ones separate AND from plain overwrite.
- Partly overlapping patterns separate AND from OR.
- A narrowing nibble sequence on one word shows that each step keeps the previous zeros.

Erase is followed by reads of the erased block and of a neighbouring block, which separates block-wide erase from page-wide or array-wide erase. A program with a beat gap, commands injected during an erase wait, and a no-op code show whether the word index, the latched command and the flags react only to accepted input.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_READ  = 2'b01,
        OP_PROG  = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_PROG,
        S_ERASE,
        S_WAIT,
        S_DONE
    } state_e;
endpackage

// File: rtl/flash_emu_array.sv
module flash_emu_array #(
    parameter int BLOCKS          = 4,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int WORDS_PER_PAGE  = 4,
    parameter int DATA_W          = 8,
    localparam int BW  = $clog2(BLOCKS),
    localparam int PW  = $clog2(PAGES_PER_BLOCK),
    localparam int IW  = $clog2(WORDS_PER_PAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BW-1:0]     blk,
    input  logic [PW-1:0]     pg,
    input  logic [IW-1:0]     idx,
    input  logic              prog_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              erase_en,
    output logic [DATA_W-1:0] rdata
);
    localparam int WPB = PAGES_PER_BLOCK * WORDS_PER_PAGE;
    localparam int NW  = BLOCKS * WPB;
    localparam int AW  = BW + PW + IW;

    logic [NW-1:0][DATA_W-1:0] mem_q;
    logic [AW-1:0]             addr;

    assign addr  = {blk, pg, idx};
    assign rdata = mem_q[addr];

    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[w] <= '1;
            end else if (erase_en && blk == BW'(w / WPB)) begin
                mem_q[w] <= '1;
            end else if (prog_we && addr == AW'(w)) begin
                mem_q[w] <= mem_q[w] & wdata;
            end
        end
    end

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(erase_en) |-> ((mem_q & ~$past(mem_q)) == '0)); // R2

    AST_ERASE_SETS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(erase_en) |-> (mem_q[{$past(blk), {(PW+IW){1'b0}}}] == '1)); // R4
endmodule

// File: rtl/flash_emu_flags.sv
module flash_emu_flags #(
    parameter int BLOCKS          = 4,
    parameter int PAGES_PER_BLOCK = 4,
    localparam int BW = $clog2(BLOCKS),
    localparam int PW = $clog2(PAGES_PER_BLOCK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] look_blk,
    input  logic [PW-1:0] look_pg,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [BW-1:0] clr_blk,
    output logic          hit
);
    logic [BLOCKS-1:0][PAGES_PER_BLOCK-1:0] flags_q;

    assign hit = flags_q[look_blk][look_pg];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (clr_en) begin
            flags_q[clr_blk] <= '0;
        end else if (set_en) begin
            flags_q[look_blk][look_pg] <= 1'b1;
        end
    end

    AST_ERASE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_en) |-> (flags_q[$past(clr_blk)] == '0)); // R5
endmodule

// File: rtl/flash_emu_ctrl.sv
module flash_emu_ctrl
    import flash_emu_pkg::*;
#(
    parameter int BLOCKS          = 4,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int WORDS_PER_PAGE  = 4,
    parameter int PROG_CYCLES     = 4,
    parameter int ERASE_CYCLES    = 16,
    localparam int BW = $clog2(BLOCKS),
    localparam int PW = $clog2(PAGES_PER_BLOCK),
    localparam int IW = $clog2(WORDS_PER_PAGE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [BW-1:0] cmd_block,
    input  logic          wr_valid,
    input  logic          flag_hit,
    output logic [BW-1:0] blk_q,
    output logic [PW-1:0] pg_q,
    output logic [IW-1:0] idx_q,
    input  logic [PW-1:0] cmd_page,
    output logic          prog_we,
    output logic          erase_en,
    output logic          flag_set,
    output logic          rd_valid,
    output logic          busy,
    output logic          done,
    output logic          prog_err
);
    localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(WORDS_PER_PAGE - 1);

    state_e        state_q, state_d;
    logic [TW-1:0] timer_q;
    logic          err_q;
    logic          accept;
    op_e           op_in;

    assign op_in  = op_e'(cmd_op);
    assign accept = (state_q == S_IDLE) && cmd_valid && (op_in != OP_NOP);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    unique case (op_in)
                        OP_READ:  state_d = S_READ;
                        OP_PROG:  state_d = S_PROG;
                        OP_ERASE: state_d = S_ERASE;
                        default:  state_d = S_IDLE;
                    endcase
                end
            end
            S_READ:  if (idx_q == LAST_IDX) state_d = S_DONE;
            S_PROG:  if (wr_valid && idx_q == LAST_IDX) state_d = S_WAIT;
            S_ERASE: state_d = S_WAIT;
            S_WAIT:  if (timer_q == '0) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            blk_q   <= '0;
            pg_q    <= '0;
            idx_q   <= '0;
            timer_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                blk_q <= cmd_block;
                pg_q  <= cmd_page;
                idx_q <= '0;
                err_q <= (op_in == OP_PROG) && flag_hit;
            end
            if (state_q == S_READ || (state_q == S_PROG && wr_valid)) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == S_PROG && wr_valid && idx_q == LAST_IDX) begin
                timer_q <= TW'(PROG_CYCLES - 1);
            end else if (state_q == S_ERASE) begin
                timer_q <= TW'(ERASE_CYCLES - 1);
            end else if (state_q == S_WAIT && timer_q != '0) begin
                timer_q <= timer_q - 1'b1;
            end
        end
    end

    always_comb begin
        busy     = (state_q != S_IDLE);
        rd_valid = (state_q == S_READ);
        done     = (state_q == S_DONE);
        prog_err = (state_q == S_DONE) && err_q;
        prog_we  = (state_q == S_PROG) && wr_valid;
        erase_en = (state_q == S_ERASE);
        flag_set = accept && (op_in == OP_PROG);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |-> done); // R5
    AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_valid && !done |=> (blk_q == $past(blk_q)) && (pg_q == $past(pg_q))); // R8
    AST_NOP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_valid && cmd_op == 2'b00 |=> !busy); // R9
    AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy && !done); // R6
endmodule

// File: rtl/flash_emu.sv
module flash_emu #(
    parameter int BLOCKS          = 4,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int WORDS_PER_PAGE  = 4,
    parameter int DATA_W          = 8,
    parameter int PROG_CYCLES     = 4,
    parameter int ERASE_CYCLES    = 16,
    localparam int BW = $clog2(BLOCKS),
    localparam int PW = $clog2(PAGES_PER_BLOCK),
    localparam int IW = $clog2(WORDS_PER_PAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BW-1:0]     cmd_block,
    input  logic [PW-1:0]     cmd_page,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              prog_err
);
    logic [BW-1:0] blk_q;
    logic [PW-1:0] pg_q;
    logic [IW-1:0] idx_q;
    logic          prog_we, erase_en, flag_set, flag_hit;

    flash_emu_ctrl #(
        .BLOCKS(BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .WORDS_PER_PAGE(WORDS_PER_PAGE),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_block(cmd_block), .wr_valid(wr_valid), .flag_hit(flag_hit),
        .blk_q(blk_q), .pg_q(pg_q), .idx_q(idx_q), .cmd_page(cmd_page),
        .prog_we(prog_we), .erase_en(erase_en), .flag_set(flag_set),
        .rd_valid(rd_valid), .busy(busy), .done(done), .prog_err(prog_err)
    );

    flash_emu_flags #(
        .BLOCKS(BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .look_blk(cmd_block), .look_pg(cmd_page),
        .set_en(flag_set), .clr_en(erase_en), .clr_blk(blk_q), .hit(flag_hit)
    );

    flash_emu_array #(
        .BLOCKS(BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .WORDS_PER_PAGE(WORDS_PER_PAGE), .DATA_W(DATA_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .blk(blk_q), .pg(pg_q), .idx(idx_q),
        .prog_we(prog_we), .wdata(wr_data), .erase_en(erase_en), .rdata(rd_data)
    );
endmodule

// File: tb/flash_emu_test.sv
module flash_emu_test;
    localparam int NB = 4, NP = 4, NWD = 4, PC = 4, EC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [1:0] cmd_block = '0;
    logic [1:0] cmd_page = '0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_valid, busy, done, prog_err;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [NB][NP][NWD];

    always #5 clk = ~clk;

    flash_emu uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_block(cmd_block), .cmd_page(cmd_page), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .done(done), .prog_err(prog_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int b, input int p);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_block = 2'(b); cmd_page = 2'(p);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic rd_page(input int b, input int p, input string tag);
        int cyc = 1;
        int n = 0;
        logic [7:0] got [NWD];
        issue(2'b01, b, p);
        while (!done && cyc < 3000) begin
            if (rd_valid && n < NWD) begin got[n] = rd_data; n++; end
            @(negedge clk); cyc++;
        end
        chk(n == NWD, {tag, " R6 word count"}, n, NWD);
        chk(cyc == NWD + 1, "R7 read done cycle", cyc, NWD + 1);
        for (int i = 0; i < NWD; i++)
            chk(got[i] == model[b][p][i], {tag, " data"}, got[i], model[b][p][i]);
    endtask

    task automatic prog_page(input int b, input int p, input logic [31:0] d,
                             input bit gap, input bit exp_err, input string tag);
        int cyc = 1;
        issue(2'b10, b, p);
        for (int i = 0; i < NWD; i++) begin
            if (gap && i == 2) begin wr_valid = 1'b0; @(negedge clk); cyc++; end
            wr_valid = 1'b1; wr_data = d[8*i +: 8];
            @(negedge clk); cyc++;
        end
        wr_valid = 1'b0;
        while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
        chk(cyc == NWD + PC + 1 + (gap ? 1 : 0), {tag, " R7/R10 program done cycle"},
            cyc, NWD + PC + 1 + (gap ? 1 : 0));
        chk(prog_err == exp_err, {tag, " R5 prog_err"}, prog_err, exp_err);
        for (int i = 0; i < NWD; i++) model[b][p][i] = model[b][p][i] & d[8*i +: 8];
    endtask

    task automatic erase_blk(input int b, input bit inject, input string tag);
        int cyc = 1;
        issue(2'b11, b, 0);
        while (!done && cyc < 3000) begin
            if (inject && cyc == 3) begin
                cmd_valid = 1'b1; cmd_op = 2'b10; cmd_block = 2'd3; cmd_page = 2'd1;
                wr_valid = 1'b1; wr_data = 8'h00;
            end else if (inject && cyc == 5) begin
                cmd_valid = 1'b1; cmd_op = 2'b11; cmd_block = 2'd0; cmd_page = 2'd0;
            end else begin
                cmd_valid = 1'b0; cmd_op = 2'b00; wr_valid = 1'b0;
            end
            @(negedge clk); cyc++;
        end
        cmd_valid = 1'b0; wr_valid = 1'b0;
        chk(cyc == EC + 2, {tag, " R7 erase done cycle"}, cyc, EC + 2);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R7 done single cycle"}, done, 0);
        for (int pp = 0; pp < NP; pp++)
            for (int i = 0; i < NWD; i++) model[b][pp][i] = 8'hFF;
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        rd_page(0, 0, "R1 erased b0p0");
        rd_page(3, 3, "R1 erased b3p3");
    endtask

    task automatic t_and_rule();
        prog_page(1, 2, 32'h55AA0FF0, 1'b0, 1'b0, "R2 first");
        rd_page(1, 2, "R2 first readback");
        prog_page(1, 2, 32'h550FFF3C, 1'b0, 1'b1, "R5 second");
        rd_page(1, 2, "R2 AND readback");
    endtask

    task automatic t_narrowing();
        logic [7:0] seq [4] = '{8'hFE, 8'hFA, 8'hF2, 8'hF0};
        for (int k = 0; k < 4; k++) begin
            prog_page(2, 0, {24'hFFFFFF, seq[k]}, 1'b0, k != 0, "R3 step");
            rd_page(2, 0, "R3 narrowing");
        end
    endtask

    task automatic t_erase();
        erase_blk(1, 1'b0, "R4 erase b1");
        rd_page(1, 2, "R4 erased page");
        rd_page(2, 0, "R4 other block kept");
        prog_page(1, 2, 32'h12345678, 1'b0, 1'b0, "R5 after erase");
        rd_page(1, 2, "R5 after erase readback");
    endtask

    task automatic t_busy_ignore();
        erase_blk(2, 1'b1, "R8 inject");
        rd_page(3, 1, "R8 ignored program");
        rd_page(0, 0, "R8 ignored erase");
        prog_page(3, 1, 32'hF0F0F0F0, 1'b0, 1'b0, "R8 flag untouched");
    endtask

    task automatic t_nop();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b0, "R9 nop busy", busy, 0);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9 nop idle", {busy, done}, 0);
    endtask

    task automatic t_gap();
        prog_page(0, 1, 32'hC3A5817E, 1'b1, 1'b0, "R10 gap");
        rd_page(0, 1, "R10 gap readback");
    endtask

    initial begin
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NP; p++)
                for (int i = 0; i < NWD; i++) model[b][p][i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_and_rule();
        t_narrowing();
        t_erase();
        t_busy_ignore();
        t_nop();
        t_gap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule